// File: doc/BRIEF.md
# Multiplexed Six-Digit Seven-Segment Scanner

This block drives six common-cathode seven-segment digits that share one segment bus. It takes six 4-bit BCD values and lights one digit at a time through a one-hot, active-high digit select. It steps through the digits quickly enough that all six appear lit at once. The segment lines are active high. Segment a is bit 0, b is bit 1, and so on up to g in bit 6. BCD values 10 to 15 turn all segments of their digit off.

The scan starts at the highest display, display 5, and steps down to display 0 before it wraps back. Each slot lasts `DWELL_CYCLES` clock cycles; at 100 MHz the default gives 1 ms. The first cycle of every slot is a switch-over cycle with every select low. In the other cycles the digit of that slot is lit. A digit's value is captured once, at the end of that switch-over cycle. If an input changes during a slot, the change shows on the next visit to that digit.

The reset input is asynchronous and active low, and its release is synchronised inside the block over two clock edges.

Top module: `mux_seg_driver`

## Requirements
- R1: While reset is held low, `seg_o` and `sel_o` are all zero. After reset is released, the first nonzero select is 0x20, which is display 5.
- R2: No more than one bit of `sel_o` is high in any cycle.
- R3: The lit selects follow the order 0x20, 0x10, 0x08, 0x04, 0x02, 0x01 and then repeat. Display k uses bit k and is driven from input bits 4k+3 to 4k.
- R4: Each slot is `DWELL_CYCLES` cycles long. It has one cycle with `sel_o` at zero followed by `DWELL_CYCLES`-1 cycles with the slot's select high.
- R5: The codes for BCD 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. Segment a is bit 0 and segment g is bit 6.
- R6: BCD values 10 to 15 produce the segment code 0x00.
- R7: A digit value is sampled at the end of its slot's switch-over cycle. A change made later in the slot does not alter the segments shown in that slot, and it appears on the next visit to that digit.
- R8: `seg_o` stays constant while a select stays lit, including the following switch-over cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| digits_i | input | 24 | Six BCD values, display k at bits 4k+3:4k |
| seg_o | output | 7 | Segment bus, a in bit 0 to g in bit 6, active high |
| sel_o | output | 6 | One-hot digit select, bit k lights display k |

## Verification
The bench builds the block with `DWELL_CYCLES` set to 8. A full frame of six slots then takes only 48 cycles. This lets every lit cycle and every switch-over cycle be compared against the expected select and segment values across whole frames for several digit patterns. At this length the bench can also change a digit in the middle of its own slot and see both the unchanged remainder of that slot and the new value on the next visit. A reset asserted in the middle of a run is checked as well.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [BCD_W-1:0] bcd_t;

  // Segment a in bit 0 through g in bit 6, active high.
  function automatic seg_t bcd_to_seg(input bcd_t v);
    seg_t s;
    case (v)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int DWELL_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_ni,
  output logic slot_first_o,
  output logic slot_last_o
);

  localparam int CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(DWELL_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign slot_first_o = (cnt_q == '0);
  assign slot_last_o  = (cnt_q == LAST_CNT);

  always_comb begin
    if (slot_last_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= LAST_CNT);

  // R4
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    slot_last_o |=> slot_first_o);

endmodule

// File: rtl/scan_index.sv
module scan_index #(
  parameter int NUM_DIGITS = 6
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          adv_i,
  output logic [$clog2(NUM_DIGITS)-1:0] idx_o
);

  localparam int IW = $clog2(NUM_DIGITS);
  localparam logic [IW-1:0] TOP_IDX = IW'(NUM_DIGITS - 1);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (adv_i) begin
      if (idx_q == '0) begin
        idx_d = TOP_IDX;
      end else begin
        idx_d = idx_q - IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= TOP_IDX;
    end else begin
      idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    idx_q <= TOP_IDX);

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    adv_i |=> idx_q == (($past(idx_q) == '0) ? TOP_IDX : $past(idx_q) - IW'(1)));

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));

endmodule

// File: rtl/seg_stage.sv
module seg_stage
  import segscan_pkg::*;
#(
  parameter int NUM_DIGITS = 6
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic [NUM_DIGITS*BCD_W-1:0]   digits_i,
  input  logic [$clog2(NUM_DIGITS)-1:0] idx_i,
  input  logic                          load_i,
  input  logic                          blank_i,
  output logic [SEG_W-1:0]              seg_o,
  output logic [NUM_DIGITS-1:0]         sel_o
);

  bcd_t dig [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_unpack
    assign dig[g] = digits_i[g*BCD_W +: BCD_W];
  end

  seg_t                  seg_q;
  seg_t                  seg_d;
  logic [NUM_DIGITS-1:0] sel_q;
  logic [NUM_DIGITS-1:0] sel_d;

  always_comb begin
    seg_d = seg_q;
    if (load_i) begin
      seg_d = bcd_to_seg(dig[idx_i]);
    end
  end

  always_comb begin
    if (blank_i) begin
      sel_d = '0;
    end else begin
      sel_d = NUM_DIGITS'(1) << idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= '0;
      sel_q <= '0;
    end else begin
      seg_q <= seg_d;
      sel_q <= sel_d;
    end
  end

  assign seg_o = seg_q;
  assign sel_o = sel_q;

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(sel_q));

  // R8
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_q != '0 && $past(sel_q) != '0) |-> $stable(seg_q));

endmodule

// File: rtl/mux_seg_driver.sv
module mux_seg_driver
  import segscan_pkg::*;
#(
  parameter int NUM_DIGITS   = 6,
  parameter int DWELL_CYCLES = 100000
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
  output logic [SEG_W-1:0]            seg_o,
  output logic [NUM_DIGITS-1:0]       sel_o
);

  localparam int IW = $clog2(NUM_DIGITS);

  logic          rst_n_int;
  logic          slot_first;
  logic          slot_last;
  logic [IW-1:0] idx;

  scan_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  scan_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
    .clk          (clk),
    .rst_ni       (rst_n_int),
    .slot_first_o (slot_first),
    .slot_last_o  (slot_last)
  );

  scan_index #(.NUM_DIGITS(NUM_DIGITS)) u_index (
    .clk    (clk),
    .rst_ni (rst_n_int),
    .adv_i  (slot_last),
    .idx_o  (idx)
  );

  seg_stage #(.NUM_DIGITS(NUM_DIGITS)) u_stage (
    .clk      (clk),
    .rst_ni   (rst_n_int),
    .digits_i (digits_i),
    .idx_i    (idx),
    .load_i   (slot_first),
    .blank_i  (slot_last),
    .seg_o    (seg_o),
    .sel_o    (sel_o)
  );

  // R4
  blank_slot_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    slot_first |-> sel_o == '0);

  // R4
  lit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !slot_first |-> sel_o != '0);

endmodule

// File: tb/sim_mux_seg_driver.sv
module sim_mux_seg_driver;

  localparam int DW = 8;
  localparam int N  = 6;
  localparam logic [23:0] PATS [5] = '{
    24'h654321, 24'h098789, 24'hFEDCBA, 24'h3A0F9C, 24'h505A07
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] digits;
  logic [6:0]  seg;
  logic [5:0]  sel;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  mux_seg_driver #(.NUM_DIGITS(N), .DWELL_CYCLES(DW)) u0 (
    .clk      (clk),
    .rst_ni   (rst_n),
    .digits_i (digits),
    .seg_o    (seg),
    .sel_o    (sel)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] v);
    logic [6:0] r;
    case (v)
      4'd0: r = 7'h3F; 4'd1: r = 7'h06; 4'd2: r = 7'h5B; 4'd3: r = 7'h4F;
      4'd4: r = 7'h66; 4'd5: r = 7'h6D; 4'd6: r = 7'h7D; 4'd7: r = 7'h07;
      4'd8: r = 7'h7F; 4'd9: r = 7'h6F;
      default: r = 7'h00;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_sel(input logic [5:0] want, input string req);
    logic [5:0] prev;
    bit hit;
    prev = sel;
    hit = 1'b0;
    for (int i = 0; i < 200 && !hit; i++) begin
      @(negedge clk);
      if (sel == want && prev == 6'h00) hit = 1'b1;
      prev = sel;
    end
    if (!hit) check(1'b0, req, sel, want);
  endtask

  // Entered at the first lit sample of display 5; leaves at the next one.
  task automatic check_frame(input logic [23:0] d, input string req);
    for (int s = 0; s < N; s++) begin
      int k;
      int bad;
      logic [5:0] es;
      logic [6:0] eg;
      k   = N - 1 - s;
      es  = 6'(1 << k);
      eg  = ref_seg(d[k*4 +: 4]);
      bad = 0;
      for (int i = 0; i < DW - 1; i++) begin
        if (i > 0) @(negedge clk);
        if (sel != es || seg != eg) bad++;
      end
      check(bad == 0, {req, " R3 R5 lit slot"}, {sel, 1'b0, seg}, {es, 1'b0, eg});
      @(negedge clk);
      check(sel == 6'h00 && seg == eg, "R4 R8 switch-over", {sel, 1'b0, seg}, {7'h00, eg});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    digits = 24'h000000;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sel == 6'h00 && seg == 7'h00, "R1 reset", {sel, 1'b0, seg}, 0);
    rst_n = 1'b1;
    wait_sel(6'h20, "R1 first select");
    check(sel == 6'h20, "R1 first select", sel, 6'h20);

    // Table walk: R3, R4, R5, R6 across patterns
    for (int p = 0; p < 5; p++) begin
      digits = PATS[p];
      wait_sel(6'h01, "R3 reach display 0");
      wait_sel(6'h20, "R3 reach display 5");
      check_frame(PATS[p], (PATS[p] == 24'hFEDCBA) ? "R6" : "R5");
      check_frame(PATS[p], "R3 repeat");
    end

    // R7: change display 5 in the middle of its own slot
    digits = 24'h111111;
    wait_sel(6'h01, "R7 sync");
    wait_sel(6'h20, "R7 sync");
    @(negedge clk);
    digits[23:20] = 4'd8;
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < DW - 2; i++) begin
        if (seg != 7'h06) bad++;
        @(negedge clk);
      end
      check(bad == 0 && sel == 6'h00, "R7 old value kept in slot", seg, 7'h06);
    end
    wait_sel(6'h20, "R7 next visit");
    check(seg == 7'h7F, "R7 new value on next visit", seg, 7'h7F);

    // R1: reset in the middle of a lit slot
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(sel == 6'h00 && seg == 7'h00, "R1 mid-run reset", {sel, 1'b0, seg}, 0);
    repeat (2) @(negedge clk);
    digits = 24'h012345;
    rst_n = 1'b1;
    wait_sel(6'h20, "R1 restart");
    check(sel == 6'h20 && seg == ref_seg(4'd0), "R1 restart at display 5", {sel, 1'b0, seg},
          {6'h20, 1'b0, ref_seg(4'd0)});
    check_frame(24'h012345, "R1 R5 after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule